// File: doc/BRIEF.md
# Two-Cluster Register Rename with On-Demand Copies

This stage renames one decoded instruction per cycle for a core with two execution clusters. Cluster A holds the complex integer units and cluster B the floating-point units, and both have simple integer units. Each cluster owns a private physical register file and its own pool of free registers. A single map table covers all architectural registers. Each integer entry keeps one mapping per cluster, and each of those mappings is valid or invalid on its own.

An external steering bit proposes a cluster for the instruction. The class of the instruction can override that proposal. When a source has no valid mapping in the executing cluster, the stage takes a fresh local register and emits a copy micro-op that moves the remote value into it. The value is then duplicated only where a consumer needs it. A destination always receives a fresh register in the executing cluster, and the mappings it replaces are reported so that commit logic can free them later through the release port.

Top module: `rn_cluster_rename`

## Requirements
- R1: After reset, integer register r (1..15) is mapped only in cluster A (cluster index 0) to physical r. Floating-point register r is mapped only in cluster B (index 1) to physical r. Physical registers 0..15 of each cluster are never free, and 16..47 are free.
- R2: All registers allocated in a cycle come from the executing cluster. The lowest-numbered free register is taken first, in the order: copy for source A, copy for source B, destination.
- R3: A source with no valid mapping in the executing cluster causes a copy micro-op. The copy reads the remote register (cp_from is the other cluster) and writes a new local register, and the renamed source reports that new register.
- R4: in_class encoding is 0 simple integer, 1 complex integer, 2 floating point. Class 1 always executes in cluster A and class 2 in cluster B, whatever in_steer says. Class 0 follows in_steer.
- R5: After a copy, the source entry is valid in both clusters, so a later consumer in either cluster needs no copy.
- R6: Renaming a destination leaves only the executing cluster's field valid. old_v bit 0 and bit 1 report, with old_preg0 and old_preg1, the cluster A and cluster B mappings that the entry held just before the write, including any copy made by the same instruction.
- R7: If the executing cluster has fewer free registers than the instruction needs, stall is high. out_valid, the copies and the destination are then low, and no map or free-list state changes.
- R8: A release (rel_valid, rel_cluster, rel_preg) returns the register to that cluster's free pool at the clock edge, where it can be allocated from the next cycle on. Releases apply during stalls too.
- R9: When both sources name the same register and it needs a copy, only copy slot 0 fires, and both renamed sources use its destination.
- R10: Architectural register 0 reads as physical 0, never causes a copy, and as a destination allocates nothing and reports nothing.
- R11: Floating-point instructions use only cluster B mappings and never emit a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present |
| in_class | input | 2 | Instruction class |
| in_steer | input | 1 | Proposed cluster for simple integer |
| src_a_v | input | 1 | Source A used |
| src_a | input | 4 | Source A architectural register |
| src_b_v | input | 1 | Source B used |
| src_b | input | 4 | Source B architectural register |
| dst_v | input | 1 | Destination used |
| dst | input | 4 | Destination architectural register |
| rel_valid | input | 1 | Release strobe |
| rel_cluster | input | 1 | Cluster of released register |
| rel_preg | input | 6 | Released physical register |
| stall | output | 1 | Not enough free registers |
| out_valid | output | 1 | Renamed instruction valid |
| out_cluster | output | 1 | Executing cluster |
| out_src_a_preg | output | 6 | Renamed source A |
| out_src_b_preg | output | 6 | Renamed source B |
| out_dst_v | output | 1 | Destination allocated |
| out_dst_preg | output | 6 | Destination physical register |
| old_v | output | 2 | Replaced mappings valid (bit 0 A, bit 1 B) |
| old_preg0 | output | 6 | Replaced cluster A register |
| old_preg1 | output | 6 | Replaced cluster B register |
| cp_v | output | 2 | Copy slots valid (slot 0 source A, slot 1 source B) |
| cp_from | output | 1 | Cluster the copies read from |
| cp_src0 | output | 6 | Copy 0 remote register |
| cp_dst0 | output | 6 | Copy 0 new local register |
| cp_src1 | output | 6 | Copy 1 remote register |
| cp_dst1 | output | 6 | Copy 1 new local register |

## Verification
The properties watch, on every cycle, the things that hold within one cycle of output. These are the class-forced cluster choice, the renamed source matching its copy's destination, duplicate sources causing a single copy, register 0 and floating-point work never causing copies, destination and copy registers being distinct, and stall blocking all output. Effects that cross cycles can only be shown by the bench's scenarios and its reference model, compared every clock. These are lowest-first allocation, invalidation of the stale cluster field, copy reuse by later consumers, stall leaving state untouched, and released registers coming back into use.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
    parameter int NUM_ARCH = 16;
    parameter int NUM_PHYS = 48;
    parameter int NUM_CL   = 2;
    parameter int MAX_ALLOC = 3;

    localparam int PW    = $clog2(NUM_PHYS);
    localparam int AW    = $clog2(NUM_ARCH);
    localparam int MW    = AW + 1;
    localparam int MAP_N = 2 * NUM_ARCH;

    typedef logic [PW-1:0] preg_t;
    typedef logic [AW-1:0] areg_t;
    typedef logic [MW-1:0] midx_t;

    typedef enum logic [1:0] {
        CLS_SIMPLE = 2'd0,
        CLS_CPLX   = 2'd1,
        CLS_FP     = 2'd2
    } iclass_t;

    typedef struct packed {
        logic  v0;
        preg_t p0;
        logic  v1;
        preg_t p1;
    } ment_t;

    function automatic logic fld_v(ment_t e, logic c);
        return c ? e.v1 : e.v0;
    endfunction

    function automatic preg_t fld_p(ment_t e, logic c);
        return c ? e.p1 : e.p0;
    endfunction

    function automatic ment_t fld_set(ment_t e, logic c, preg_t p);
        ment_t r;
        r = e;
        if (c) begin
            r.v1 = 1'b1;
            r.p1 = p;
        end else begin
            r.v0 = 1'b1;
            r.p0 = p;
        end
        return r;
    endfunction
endpackage

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
module rn_free_list
    import rn_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             take_n,
    input  logic                   rel_en,
    input  preg_t                  rel_idx,
    output preg_t [MAX_ALLOC-1:0]  pick,
    output logic [PW:0]            avail
);
    logic [NUM_PHYS-1:0] freev;
    logic [NUM_PHYS-1:0] clr;
    logic [NUM_PHYS-1:0] setm;

    // successive lowest-free search over a shrinking mask
    always_comb begin
        logic [NUM_PHYS-1:0] m;
        m = freev;
        for (int k = 0; k < MAX_ALLOC; k++) begin
            pick[k] = '0;
            for (int i = NUM_PHYS - 1; i >= 0; i--) begin
                if (m[i]) pick[k] = PW'(i);
            end
            m[pick[k]] = 1'b0;
        end
    end

    always_comb begin
        avail = '0;
        for (int i = 0; i < NUM_PHYS; i++) avail = avail + (PW+1)'(freev[i]);
    end

    always_comb begin
        clr = '0;
        for (int k = 0; k < MAX_ALLOC; k++) begin
            if (2'(k) < take_n) clr[pick[k]] = 1'b1;
        end
        setm = '0;
        if (rel_en) setm[rel_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PHYS; i++) freev[i] <= (i >= NUM_ARCH);
        end else begin
            freev <= (freev & ~clr) | setm;
        end
    end
endmodule

// File: rtl/rn_map_table.sv
`timescale 1ns/1ps
module rn_map_table
    import rn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  midx_t [MAX_ALLOC-1:0] rd_idx,
    output ment_t [MAX_ALLOC-1:0] rd_ent,
    input  logic  [MAX_ALLOC-1:0] wr_en,
    input  midx_t [MAX_ALLOC-1:0] wr_idx,
    input  ment_t [MAX_ALLOC-1:0] wr_ent
);
    ment_t tbl [MAP_N];

    always_comb begin
        for (int k = 0; k < MAX_ALLOC; k++) rd_ent[k] = tbl[rd_idx[k]];
    end

    // higher-numbered write port wins on the same entry
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAP_N; i++) begin
                if (i < NUM_ARCH) tbl[i] <= '{v0: 1'b1, p0: PW'(i), v1: 1'b0, p1: '0};
                else              tbl[i] <= '{v0: 1'b0, p0: '0, v1: 1'b1, p1: PW'(i - NUM_ARCH)};
            end
        end else begin
            for (int k = 0; k < MAX_ALLOC; k++) begin
                if (wr_en[k]) tbl[wr_idx[k]] <= wr_ent[k];
            end
        end
    end
endmodule

// File: rtl/rn_cluster_rename.sv
`timescale 1ns/1ps
module rn_cluster_rename
    import rn_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  in_class,
    input  logic        in_steer,
    input  logic        src_a_v,
    input  logic [3:0]  src_a,
    input  logic        src_b_v,
    input  logic [3:0]  src_b,
    input  logic        dst_v,
    input  logic [3:0]  dst,
    input  logic        rel_valid,
    input  logic        rel_cluster,
    input  logic [5:0]  rel_preg,
    output logic        stall,
    output logic        out_valid,
    output logic        out_cluster,
    output logic [5:0]  out_src_a_preg,
    output logic [5:0]  out_src_b_preg,
    output logic        out_dst_v,
    output logic [5:0]  out_dst_preg,
    output logic [1:0]  old_v,
    output logic [5:0]  old_preg0,
    output logic [5:0]  old_preg1,
    output logic [1:0]  cp_v,
    output logic        cp_from,
    output logic [5:0]  cp_src0,
    output logic [5:0]  cp_dst0,
    output logic [5:0]  cp_src1,
    output logic [5:0]  cp_dst1
);
    iclass_t cls;
    logic    cl, is_fp, go;
    logic    a_nz, b_nz, d_nz, dup;
    logic    need_a, need_b, need_d;
    logic [1:0] n_alloc, d_slot;

    preg_t [MAX_ALLOC-1:0] pick_c  [NUM_CL];
    logic  [PW:0]          avail_c [NUM_CL];
    preg_t [MAX_ALLOC-1:0] pick_s;
    logic  [PW:0]          avail_s;

    midx_t [MAX_ALLOC-1:0] ridx;
    ment_t [MAX_ALLOC-1:0] rent;
    logic  [MAX_ALLOC-1:0] wen;
    ment_t [MAX_ALLOC-1:0] went;

    ment_t ea, eb, ed, ea_new, eb_new, pre_d, d_new;
    preg_t pa, pb, pd;

    assign cls = iclass_t'(in_class);

    always_comb begin
        unique case (cls)
            CLS_CPLX: cl = 1'b0;
            CLS_FP:   cl = 1'b1;
            default:  cl = in_steer;
        endcase
        is_fp = (cls == CLS_FP);
    end

    assign ridx = {{is_fp, dst}, {is_fp, src_b}, {is_fp, src_a}};
    assign ea = rent[0];
    assign eb = rent[1];
    assign ed = rent[2];

    rn_map_table u_map (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (ridx),
        .rd_ent (rent),
        .wr_en  (wen),
        .wr_idx (ridx),
        .wr_ent (went)
    );

    for (genvar c = 0; c < NUM_CL; c++) begin : g_fl
        rn_free_list u_fl (
            .clk     (clk),
            .rst     (rst),
            .take_n  ((go && cl == 1'(c)) ? n_alloc : 2'd0),
            .rel_en  (rel_valid && rel_cluster == 1'(c)),
            .rel_idx (rel_preg),
            .pick    (pick_c[c]),
            .avail   (avail_c[c])
        );
    end

    assign pick_s  = pick_c[cl];
    assign avail_s = avail_c[cl];

    always_comb begin
        a_nz   = src_a_v && (src_a != '0);
        b_nz   = src_b_v && (src_b != '0);
        d_nz   = dst_v && (dst != '0);
        dup    = a_nz && b_nz && (src_a == src_b);
        need_a = in_valid && a_nz && !fld_v(ea, cl);
        need_b = in_valid && b_nz && !fld_v(eb, cl) && !(need_a && dup);
        need_d = in_valid && d_nz;
        n_alloc = {1'b0, need_a} + {1'b0, need_b} + {1'b0, need_d};
        stall  = in_valid && ((PW+1)'(n_alloc) > avail_s);
        go     = in_valid && !stall;
        d_slot = {1'b0, need_a} + {1'b0, need_b};
        pa     = pick_s[0];
        pb     = need_a ? pick_s[1] : pick_s[0];
        pd     = pick_s[d_slot];
        ea_new = fld_set(ea, cl, pa);
        eb_new = fld_set(eb, cl, pb);
        if (need_a && src_a == dst)      pre_d = ea_new;
        else if (need_b && src_b == dst) pre_d = eb_new;
        else                             pre_d = ed;
        d_new  = cl ? '{v0: 1'b0, p0: '0, v1: 1'b1, p1: pd}
                    : '{v0: 1'b1, p0: pd, v1: 1'b0, p1: '0};
    end

    assign wen  = {go && need_d, go && need_b, go && need_a};
    assign went = {d_new, eb_new, ea_new};

    always_comb begin
        out_valid      = go;
        out_cluster    = go ? cl : 1'b0;
        out_src_a_preg = (!go || !a_nz) ? '0 : (need_a ? pa : fld_p(ea, cl));
        if (!go || !b_nz)         out_src_b_preg = '0;
        else if (need_b)          out_src_b_preg = pb;
        else if (dup && need_a)   out_src_b_preg = pa;
        else                      out_src_b_preg = fld_p(eb, cl);
        out_dst_v      = go && need_d;
        out_dst_preg   = out_dst_v ? pd : '0;
        old_v          = out_dst_v ? {pre_d.v1, pre_d.v0} : 2'b00;
        old_preg0      = old_v[0] ? pre_d.p0 : '0;
        old_preg1      = old_v[1] ? pre_d.p1 : '0;
        cp_v           = go ? {need_b, need_a} : 2'b00;
        cp_from        = (cp_v != 2'b00) ? ~cl : 1'b0;
        cp_src0        = cp_v[0] ? fld_p(ea, ~cl) : '0;
        cp_dst0        = cp_v[0] ? pa : '0;
        cp_src1        = cp_v[1] ? fld_p(eb, ~cl) : '0;
        cp_dst1        = cp_v[1] ? pb : '0;
    end
endmodule

// File: rtl/rn_rename_chk.sv
`timescale 1ns/1ps
module rn_rename_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] in_class,
    input logic       src_a_v,
    input logic [3:0] src_a,
    input logic       src_b_v,
    input logic [3:0] src_b,
    input logic       stall,
    input logic       out_valid,
    input logic       out_cluster,
    input logic [5:0] out_src_a_preg,
    input logic [5:0] out_src_b_preg,
    input logic       out_dst_v,
    input logic [5:0] out_dst_preg,
    input logic [1:0] cp_v,
    input logic [5:0] cp_dst0,
    input logic [5:0] cp_dst1
);
    a_r4_cplx_in_a: assert property (@(posedge clk) disable iff (rst)
        out_valid && in_class == 2'd1 |-> out_cluster == 1'b0);
    a_r4_fp_in_b: assert property (@(posedge clk) disable iff (rst)
        out_valid && in_class == 2'd2 |-> out_cluster == 1'b1);
    a_r7_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        stall |-> !out_valid && cp_v == 2'b00 && !out_dst_v);
    a_r3_src_a_copy: assert property (@(posedge clk) disable iff (rst)
        cp_v[0] |-> out_src_a_preg == cp_dst0);
    a_r3_src_b_copy: assert property (@(posedge clk) disable iff (rst)
        cp_v[1] |-> out_src_b_preg == cp_dst1);
    a_r9_single_copy: assert property (@(posedge clk) disable iff (rst)
        out_valid && src_a_v && src_b_v && src_a == src_b |-> !cp_v[1]);
    a_r10_zero_no_copy: assert property (@(posedge clk) disable iff (rst)
        src_a_v && src_a == 4'd0 |-> !cp_v[0]);
    a_r11_fp_no_copy: assert property (@(posedge clk) disable iff (rst)
        in_class == 2'd2 |-> cp_v == 2'b00);
    a_r2_dst_differs: assert property (@(posedge clk) disable iff (rst)
        out_dst_v && cp_v[0] |-> out_dst_preg != cp_dst0);
endmodule

bind rn_cluster_rename rn_rename_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_class       (in_class),
    .src_a_v        (src_a_v),
    .src_a          (src_a),
    .src_b_v        (src_b_v),
    .src_b          (src_b),
    .stall          (stall),
    .out_valid      (out_valid),
    .out_cluster    (out_cluster),
    .out_src_a_preg (out_src_a_preg),
    .out_src_b_preg (out_src_b_preg),
    .out_dst_v      (out_dst_v),
    .out_dst_preg   (out_dst_preg),
    .cp_v           (cp_v),
    .cp_dst0        (cp_dst0),
    .cp_dst1        (cp_dst1)
);

// File: tb/rn_cluster_rename_tb.sv
`timescale 1ns/1ps
module rn_cluster_rename_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 0, in_steer = 0, src_a_v = 0, src_b_v = 0, dst_v = 0;
    logic [1:0] in_class = 0;
    logic [3:0] src_a = 0, src_b = 0, dst = 0;
    logic rel_valid = 0, rel_cluster = 0;
    logic [5:0] rel_preg = 0;
    logic stall, out_valid, out_cluster, out_dst_v, cp_from;
    logic [5:0] out_src_a_preg, out_src_b_preg, out_dst_preg, old_preg0, old_preg1;
    logic [5:0] cp_src0, cp_dst0, cp_src1, cp_dst1;
    logic [1:0] old_v, cp_v;

    always #4 clk = ~clk;

    rn_cluster_rename u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class), .in_steer(in_steer),
        .src_a_v(src_a_v), .src_a(src_a), .src_b_v(src_b_v), .src_b(src_b),
        .dst_v(dst_v), .dst(dst), .rel_valid(rel_valid), .rel_cluster(rel_cluster),
        .rel_preg(rel_preg), .stall(stall), .out_valid(out_valid), .out_cluster(out_cluster),
        .out_src_a_preg(out_src_a_preg), .out_src_b_preg(out_src_b_preg),
        .out_dst_v(out_dst_v), .out_dst_preg(out_dst_preg), .old_v(old_v),
        .old_preg0(old_preg0), .old_preg1(old_preg1), .cp_v(cp_v), .cp_from(cp_from),
        .cp_src0(cp_src0), .cp_dst0(cp_dst0), .cp_src1(cp_src1), .cp_dst1(cp_dst1)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state: validity, register and free flags per cluster
    bit mv [2][32];
    int mp [2][32];
    bit fr [2][48];
    int relq [$];

    int e_valid, e_stall, e_cl, e_sa, e_sb, e_dv, e_dp, e_ov, e_o0, e_o1;
    int e_cv, e_cf, e_c0s, e_c0d, e_c1s, e_c1d;

    task automatic chk(string tag, string nm, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < 16; r++) begin
            mv[0][r] = 1; mp[0][r] = r; mv[1][r] = 0; mp[1][r] = 0;
            mv[0][16+r] = 0; mp[0][16+r] = 0; mv[1][16+r] = 1; mp[1][16+r] = r;
        end
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 48; i++) fr[c][i] = (i >= 16);
    endtask

    function automatic int take(int c);
        for (int i = 0; i < 48; i++) begin
            if (fr[c][i]) begin
                fr[c][i] = 0;
                return i;
            end
        end
        return 0;
    endfunction

    task automatic model_step();
        int cl, oc, base, ia, ib, id, n, cnt, p;
        bit an, bn, dn, na, nb, dup;
        e_valid = 0; e_stall = 0; e_cl = 0; e_sa = 0; e_sb = 0; e_dv = 0; e_dp = 0;
        e_ov = 0; e_o0 = 0; e_o1 = 0; e_cv = 0; e_cf = 0;
        e_c0s = 0; e_c0d = 0; e_c1s = 0; e_c1d = 0;
        cl = (in_class == 1) ? 0 : (in_class == 2) ? 1 : int'(in_steer);
        oc = 1 - cl;
        base = (in_class == 2) ? 16 : 0;
        ia = base + int'(src_a); ib = base + int'(src_b); id = base + int'(dst);
        if (in_valid) begin
            an = src_a_v && src_a != 0;
            bn = src_b_v && src_b != 0;
            dn = dst_v && dst != 0;
            dup = an && bn && src_a == src_b;
            na = an && !mv[cl][ia];
            nb = bn && !mv[cl][ib] && !(na && dup);
            n = int'(na) + int'(nb) + int'(dn);
            cnt = 0;
            for (int i = 0; i < 48; i++) cnt += int'(fr[cl][i]);
            if (n > cnt) e_stall = 1;
            else begin
                e_valid = 1; e_cl = cl;
                if (na) begin
                    p = take(cl); e_cv += 1; e_c0s = mp[oc][ia]; e_c0d = p;
                    mv[cl][ia] = 1; mp[cl][ia] = p;
                end
                if (nb) begin
                    p = take(cl); e_cv += 2; e_c1s = mp[oc][ib]; e_c1d = p;
                    mv[cl][ib] = 1; mp[cl][ib] = p;
                end
                if (e_cv != 0) e_cf = oc;
                e_sa = an ? mp[cl][ia] : 0;
                e_sb = bn ? mp[cl][ib] : 0;
                if (dn) begin
                    p = take(cl);
                    e_ov = int'(mv[0][id]) + 2 * int'(mv[1][id]);
                    e_o0 = mv[0][id] ? mp[0][id] : 0;
                    e_o1 = mv[1][id] ? mp[1][id] : 0;
                    if (mv[0][id]) relq.push_back(mp[0][id]);
                    if (mv[1][id]) relq.push_back(64 + mp[1][id]);
                    mv[cl][id] = 1; mp[cl][id] = p; mv[oc][id] = 0;
                    e_dv = 1; e_dp = p;
                end
            end
        end
        if (rel_valid) fr[rel_cluster][rel_preg] = 1;
    endtask

    task automatic compare(string tag);
        chk(tag, "stall", int'(stall), e_stall);
        chk(tag, "out_valid", int'(out_valid), e_valid);
        chk(tag, "out_cluster", int'(out_cluster), e_cl);
        chk(tag, "src_a_preg", int'(out_src_a_preg), e_sa);
        chk(tag, "src_b_preg", int'(out_src_b_preg), e_sb);
        chk(tag, "dst_v", int'(out_dst_v), e_dv);
        chk(tag, "dst_preg", int'(out_dst_preg), e_dp);
        chk(tag, "old_v", int'(old_v), e_ov);
        chk(tag, "old_preg0", int'(old_preg0), e_o0);
        chk(tag, "old_preg1", int'(old_preg1), e_o1);
        chk(tag, "cp_v", int'(cp_v), e_cv);
        chk(tag, "cp_from", int'(cp_from), e_cf);
        chk(tag, "cp_src0", int'(cp_src0), e_c0s);
        chk(tag, "cp_dst0", int'(cp_dst0), e_c0d);
        chk(tag, "cp_src1", int'(cp_src1), e_c1s);
        chk(tag, "cp_dst1", int'(cp_dst1), e_c1d);
    endtask

    // drive at the falling edge, compare before the rising edge
    task automatic cyc(string tag, bit v, int cls, bit st, bit av, int a, bit bv, int b,
                       bit dv, int d, bit rv, bit rc, int rp);
        in_valid = v; in_class = 2'(cls); in_steer = st;
        src_a_v = av; src_a = 4'(a); src_b_v = bv; src_b = 4'(b);
        dst_v = dv; dst = 4'(d);
        rel_valid = rv; rel_cluster = rc; rel_preg = 6'(rp);
        #2;
        model_step();
        compare(tag);
        @(negedge clk);
    endtask

    task automatic release_one(string tag);
        int e;
        if (relq.size() == 0) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        else begin
            e = relq.pop_front();
            cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, e >= 64, e % 64);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle output and reset mappings in both clusters
        cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R1", 1, 0, 0, 1, 3, 1, 7, 0, 0, 0, 0, 0);
        cyc("R1", 1, 2, 1, 1, 4, 1, 9, 0, 0, 0, 0, 0);
        // R3: integer source read in cluster B needs a copy
        cyc("R3", 1, 0, 1, 1, 3, 0, 0, 0, 0, 0, 0, 0);
        // R5: second consumer in B and consumer in A need no copy
        cyc("R5", 1, 0, 1, 1, 3, 0, 0, 0, 0, 0, 0, 0);
        cyc("R5", 1, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0, 0);
        // R9: duplicate remote sources share one copy
        cyc("R9", 1, 0, 1, 1, 5, 1, 5, 0, 0, 0, 0, 0);
        // R2: two copies then destination, lowest first
        cyc("R2", 1, 0, 1, 1, 6, 1, 7, 1, 8, 0, 0, 0);
        // R6: destination over a replicated register reports both fields
        cyc("R6", 1, 0, 0, 1, 1, 0, 0, 1, 3, 0, 0, 0);
        // R6: copy and destination on the same register in one instruction
        cyc("R6", 1, 0, 1, 1, 9, 0, 0, 1, 9, 0, 0, 0);
        // R10: register zero
        cyc("R10", 1, 0, 1, 1, 0, 1, 0, 1, 0, 0, 0, 0);
        // R4: class overrides steering
        cyc("R4", 1, 1, 1, 1, 9, 1, 2, 1, 10, 0, 0, 0);
        cyc("R4", 1, 2, 0, 1, 2, 1, 3, 1, 4, 0, 0, 0);
        // R11: floating-point sources never copy
        cyc("R11", 1, 2, 0, 1, 4, 1, 5, 1, 6, 0, 0, 0);
        // R7: drain cluster B until stalls appear
        for (int i = 0; i < 40; i++) cyc("R7", 1, 0, 1, 1, 11, 0, 0, 1, 12, 0, 0, 0);
        cyc("R7", 1, 0, 1, 1, 13, 1, 14, 1, 15, 0, 0, 0);
        // R8: releases refill the pool, then allocation resumes
        for (int i = 0; i < 6; i++) release_one("R8");
        cyc("R8", 1, 0, 1, 1, 13, 1, 14, 1, 15, 0, 0, 0);
        cyc("R8", 1, 0, 1, 1, 2, 0, 0, 1, 12, 1, 0, 16);
        // R2: mixed traffic with ongoing releases
        for (int i = 0; i < 400; i++) begin
            int e;
            bit rv;
            int rp;
            bit rc;
            rv = 0; rp = 0; rc = 0;
            if (relq.size() > 0 && ($urandom % 3) != 0) begin
                e = relq.pop_front();
                rv = 1; rc = e >= 64; rp = e % 64;
            end
            cyc("R2", ($urandom % 4) != 0, int'($urandom % 3), 1'($urandom),
                1'($urandom), int'($urandom % 16), 1'($urandom), int'($urandom % 16),
                1'($urandom), int'($urandom % 16), rv, rc, rp);
        end
        finish_run();
    end
endmodule